// File: doc/BRIEF.md
# Prescaled Auto-Reload Countdown Timer

This block is one countdown timer channel behind a small word-addressed register port. The peripheral clock passes through an 8-bit prescaler and then a power-of-two divider chosen by a select code. Together they produce a tick. One select code swaps the divided clock for an external tick input. Each tick decrements a 32-bit working counter. When the counter is at zero and a tick arrives, the counter expires: an interrupt pending flag is set and, with auto-reload on, the counter is refilled from its buffer register.

Software writes a count buffer and a compare buffer. It sets the manual-update control bit to copy both buffers into the working registers, then writes start with manual update cleared in one control write. The live count and the working compare value can be read at any time.

The register port is a plain single-cycle port. A write takes effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. There is no back-pressure: every access completes in its own cycle.

Word addresses: 0 prescaler, 1 configuration, 2 control, 3 count buffer, 4 compare buffer, 5 count observation (read-only), 6 compare observation (read-only), 7 status, 8 interrupt enable.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads 0, start is clear, the count observation reads 0 and `irq` is low.
- R2: A prescaler value N (address 0, bits 7:0) produces one prescaled pulse every N+1 clock cycles while the timer runs.
- R3: The select field (address 1, bits 19:16) divides the prescaled pulses as follows: code 0 by 1, 1 by 2, 2 by 4, 3 by 8 and 4 by 16. Any code of 5 or higher makes each cycle with `ext_tick` high one tick.
- R4: With auto-reload set (control bit 22), a count buffer value C gives an expiry every C+1 ticks, and the counter reloads C at each expiry.
- R5: While manual update (control bit 21) is set, the count and compare buffers are copied into the working count and compare registers each cycle, and no counting happens.
- R6: The counter decrements only while start (control bit 20) is set and manual update is clear. Clearing start freezes the count.
- R7: With auto-reload clear, the counter stays at 0 after expiry and the start bit clears itself.
- R8: Each expiry sets the pending flag (status bit 0). Writing 1 to that bit clears it and writing 0 leaves it. An expiry in the same cycle as a clearing write leaves the flag set.
- R9: `irq` equals the pending flag ANDed with interrupt enable bit 0 at address 8.
- R10: Address 5 returns the live working count and address 6 returns the working compare value.
- R11: Writes to the read-only addresses 5 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ext_tick | input | 1 | External tick, one pulse per cycle high, already synchronous to `clk` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the counter steps by at most one, and only on a tick;
- manual update loads both working registers;
- the counter reloads from the buffer or rests at zero after an expiry;
- an expiry always leaves the pending flag set;
- a one-shot expiry clears start.

Only the bench scenarios can show:
- the exact expiry periods for each prescaler and select setting;
- the external tick path;
- the ordering of a clear and an expiry in the same cycle;
- the fact that read-only addresses ignore writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_PSC  = 0;
  localparam int unsigned ADDR_CFG  = 1;
  localparam int unsigned ADDR_CTRL = 2;
  localparam int unsigned ADDR_CNTB = 3;
  localparam int unsigned ADDR_CMPB = 4;
  localparam int unsigned ADDR_CNTO = 5;
  localparam int unsigned ADDR_CMPO = 6;
  localparam int unsigned ADDR_STAT = 7;
  localparam int unsigned ADDR_IEN  = 8;

  localparam int unsigned SEL_LSB   = 16;
  localparam int unsigned CTRL_LSB  = 20;

  typedef struct packed {
    logic autoreload;
    logic manual;
    logic start;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned PSC_W     = 8,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned MAX_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_tick,
  output logic             tick
);
  localparam int unsigned EXT_CODE = MAX_SHIFT + 1;

  logic [PSC_W-1:0]     pcnt;
  logic [MAX_SHIFT-1:0] dcnt;
  logic [MAX_SHIFT-1:0] mask;
  logic                 pre;
  logic                 div_tick;

  assign pre = run && (pcnt >= psc);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (pre) begin
      pcnt <= '0;
      dcnt <= dcnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  // Mask of low divider bits that must all be one for a tick.
  always_comb begin
    mask = '0;
    for (int i = 0; i < MAX_SHIFT; i++) begin
      if (int'(sel) > i) mask[i] = 1'b1;
    end
  end

  assign div_tick = pre && ((dcnt & mask) == mask);
  assign tick = (int'(sel) >= EXT_CODE) ? (run && ext_tick) : div_tick;

  // R2: a prescaled pulse always restarts the prescale count
  a_r2_prescale_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (pre && run) |=> (pcnt == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             manual,
  input  logic             autoreload,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic             expire,
  output logic             stop_req
);
  logic step;

  assign step     = run && tick;
  assign expire   = step && (cnt == '0);
  assign stop_req = expire && !autoreload;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      cmp <= '0;
    end else if (manual) begin
      cnt <= cnt_buf;
      cmp <= cmp_buf;
    end else if (step) begin
      if (cnt == '0) begin
        if (autoreload) cnt <= cnt_buf;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R5: manual update copies both buffers
  a_r5_manual_load: assert property (@(posedge clk) disable iff (!rst_n)
    manual |=> (cnt == $past(cnt_buf) && cmp == $past(cmp_buf)));
  // R6: without a tick the count holds
  a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual && !step) |=> (cnt == $past(cnt)));
  // R4: a running nonzero count steps down by exactly one
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual && step && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  // R4: expiry with auto-reload refills from the buffer
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual && expire && autoreload) |=> (cnt == $past(cnt_buf)));
  // R7: one-shot expiry rests at zero
  a_r7_rest_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual && stop_req) |=> (cnt == '0));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              expire,
  input  logic              stop_req,
  input  logic [CNT_W-1:0]  cnt_obs,
  input  logic [CNT_W-1:0]  cmp_obs,
  output logic [PSC_W-1:0]  psc,
  output logic [SEL_W-1:0]  sel,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  cnt_buf,
  output logic [CNT_W-1:0]  cmp_buf,
  output logic              pend,
  output logic              ien,
  output logic [31:0]       rdata
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned k);
    return a == ADDR_W'(k);
  endfunction

  logic wr_ctrl;
  logic clr_pend;

  assign wr_ctrl  = wr && hit(addr, ADDR_CTRL);
  assign clr_pend = wr && hit(addr, ADDR_STAT) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc     <= '0;
      sel     <= '0;
      ctrl    <= '0;
      cnt_buf <= '0;
      cmp_buf <= '0;
      pend    <= 1'b0;
      ien     <= 1'b0;
    end else begin
      if (wr && hit(addr, ADDR_PSC))  psc     <= wdata[PSC_W-1:0];
      if (wr && hit(addr, ADDR_CFG))  sel     <= wdata[SEL_LSB +: SEL_W];
      if (wr && hit(addr, ADDR_CNTB)) cnt_buf <= wdata[CNT_W-1:0];
      if (wr && hit(addr, ADDR_CMPB)) cmp_buf <= wdata[CNT_W-1:0];
      if (wr && hit(addr, ADDR_IEN))  ien     <= wdata[0];
      if (wr_ctrl)       ctrl       <= wdata[CTRL_LSB +: 3];
      else if (stop_req) ctrl.start <= 1'b0;
      if (expire)        pend <= 1'b1;
      else if (clr_pend) pend <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit(addr, ADDR_PSC))  rdata[PSC_W-1:0]          = psc;
    if (hit(addr, ADDR_CFG))  rdata[SEL_LSB +: SEL_W]   = sel;
    if (hit(addr, ADDR_CTRL)) rdata[CTRL_LSB +: 3]      = ctrl;
    if (hit(addr, ADDR_CNTB)) rdata[CNT_W-1:0]          = cnt_buf;
    if (hit(addr, ADDR_CMPB)) rdata[CNT_W-1:0]          = cmp_buf;
    if (hit(addr, ADDR_CNTO)) rdata[CNT_W-1:0]          = cnt_obs;
    if (hit(addr, ADDR_CMPO)) rdata[CNT_W-1:0]          = cmp_obs;
    if (hit(addr, ADDR_STAT)) rdata[0]                  = pend;
    if (hit(addr, ADDR_IEN))  rdata[0]                  = ien;
  end

  // R8: an expiry always leaves the flag set, whatever else is written
  a_r8_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend);
  // R7: a one-shot expiry clears start unless control is rewritten
  a_r7_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !wr_ctrl) |=> !ctrl.start);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PSC_W     = 8,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned MAX_SHIFT = 4,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ext_tick,
  output logic              irq
);
  logic [PSC_W-1:0] psc;
  logic [SEL_W-1:0] sel;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt_buf, cmp_buf, cnt, cmp;
  logic             pend, ien, tick, expire, stop_req, run;

  assign run = ctrl.start && !ctrl.manual;
  assign irq = pend && ien;

  tmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .expire(expire), .stop_req(stop_req), .cnt_obs(cnt), .cmp_obs(cmp),
    .psc(psc), .sel(sel), .ctrl(ctrl), .cnt_buf(cnt_buf), .cmp_buf(cmp_buf),
    .pend(pend), .ien(ien), .rdata(bus_rdata)
  );

  tmr_prescale #(.PSC_W(PSC_W), .SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .psc(psc), .sel(sel),
    .ext_tick(ext_tick), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .manual(ctrl.manual),
    .autoreload(ctrl.autoreload), .cnt_buf(cnt_buf), .cmp_buf(cmp_buf),
    .cnt(cnt), .cmp(cmp), .expire(expire), .stop_req(stop_req)
  );

  // R9: a raised interrupt implies the flag was set by an expiry or held
  a_r9_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (pend && ($past(expire) || $past(pend))));
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {prescaler[47:40], select[39:32], count[31:0]}
  localparam logic [47:0] VEC [NVEC] = '{
    {8'd0, 8'd0, 32'd5},
    {8'd6, 8'd0, 32'd2},
    {8'd1, 8'd2, 32'd3},
    {8'd0, 8'd4, 32'd1},
    {8'd2, 8'd1, 32'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_tick = 1'b0;
  logic        irq;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick(ext_tick), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 4'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    waitc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a <= 8; a++) begin
      rd(a, v);
      check("R1 reset register", v, 32'h0);
    end
    check("R1 irq low", {31'b0, irq}, 32'h0);

    // R2 R3 R4 table of periods
    for (int k = 0; k < NVEC; k++) begin
      int p, c, total;
      p = (int'(VEC[k][47:40]) + 1) * (1 << VEC[k][39:32]);
      c = int'(VEC[k][31:0]);
      total = (c + 1) * p;
      wr(0, {24'b0, VEC[k][47:40]});
      wr(1, {8'b0, VEC[k][39:32], 16'b0});
      wr(3, VEC[k][31:0]);
      wr(2, 32'h6 << 20);
      wr(2, 32'h5 << 20);
      waitc(total - 1);
      rd(7, v); check("R2/R3/R4 no early expiry", v, 32'h0);
      waitc(1);
      rd(7, v); check("R2/R3/R4 expiry on period", v, 32'h1);
      rd(5, v); check("R4 reload value", v, VEC[k][31:0]);
      wr(7, 32'h1);
      wr(2, 32'h0);
    end
    rd(7, v); check("R8 cleared after table", v, 32'h0);

    // R11 write to read-only address
    rd(5, v);
    wr(5, 32'hDEAD_BEEF);
    wr(6, 32'hDEAD_BEEF);
    begin
      logic [31:0] w;
      rd(5, w); check("R11 count obs unchanged", w, v);
      rd(6, w); check("R11 compare obs unchanged", w, 32'h0);
    end

    // R5 R10 manual update holds counting
    wr(0, 0); wr(1, 0);
    wr(3, 32'h1234); wr(4, 32'hABCD);
    wr(2, 32'h3 << 20);
    waitc(1);
    rd(5, v); check("R5/R10 count loaded", v, 32'h1234);
    rd(6, v); check("R5/R10 compare loaded", v, 32'hABCD);
    waitc(5);
    rd(5, v); check("R5/R6 no count with manual", v, 32'h1234);

    // R6 run and freeze
    wr(3, 100);
    wr(2, 32'h6 << 20);
    wr(2, 32'h5 << 20);
    waitc(10);
    rd(5, v); check("R6 counting", v, 90);
    wr(2, 0);
    waitc(5);
    rd(5, v); check("R6 frozen after stop", v, 89);

    // R7 one-shot
    wr(3, 3);
    wr(2, 32'h2 << 20);
    wr(2, 32'h1 << 20);
    waitc(3);
    rd(7, v); check("R7 not yet expired", v, 32'h0);
    waitc(1);
    rd(7, v); check("R7/R8 one-shot expired", v, 32'h1);
    rd(5, v); check("R7 count zero", v, 32'h0);
    rd(2, v); check("R7 start self-cleared", v, 32'h0);
    waitc(5);
    rd(5, v); check("R7 stays zero", v, 32'h0);

    // R9 irq gating
    check("R9 irq off without enable", {31'b0, irq}, 32'h0);
    wr(8, 1);
    check("R9 irq on", {31'b0, irq}, 32'h1);
    wr(8, 0);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(8, 1);

    // R8 write 0 keeps, write 1 clears
    wr(7, 0);
    rd(7, v); check("R8 write zero keeps", v, 32'h1);
    wr(7, 1);
    rd(7, v); check("R8 write one clears", v, 32'h0);
    check("R9 irq drops with flag", {31'b0, irq}, 32'h0);

    // R8 set wins over a clear in the same cycle (expiry every 5 cycles)
    wr(3, 4);
    wr(2, 32'h6 << 20);
    wr(2, 32'h5 << 20);
    waitc(9);
    wr(7, 1);
    rd(7, v); check("R8 set wins over clear", v, 32'h1);
    wr(2, 0);
    wr(7, 1);

    // R3 external tick source
    wr(0, 3);
    wr(1, 32'h5 << 16);
    wr(3, 10);
    wr(2, 32'h6 << 20);
    wr(2, 32'h5 << 20);
    waitc(8);
    rd(5, v); check("R3 external idle holds", v, 10);
    for (int i = 0; i < 3; i++) begin
      ext_tick = 1'b1; @(negedge clk);
      ext_tick = 1'b0; @(negedge clk);
    end
    rd(5, v); check("R3 external three ticks", v, 7);
    wr(1, 32'h9 << 16);
    ext_tick = 1'b1; @(negedge clk);
    ext_tick = 1'b0; @(negedge clk);
    rd(5, v); check("R3 high code uses external", v, 6);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule